// File: doc/BRIEF.md
# Nibble-Bus Firmware Memory Write Target

This block is the target side of a narrow bus that carries address and data over four shared lines. The host marks a new transfer by pulling an active-low frame strobe. The block watches the bus nibble that is present in the last clock the strobe is low and treats the code 1110b as the opening of a firmware-memory write. It then checks a device-select nibble against a 4-bit strap, gathers a 28-bit address and one byte of data, and checks that the size field asks for a single byte. It then takes over the bus to answer with a ready-sync code.

The whole transfer is a fixed seventeen clocks. A seven-nibble address and a two-nibble data byte follow the select nibble. The host then hands the bus over in two clocks. The target drives one ready-sync clock, then 1111b for one clock, then releases the bus. In the ready-sync clock the block pulses a one-cycle write request that carries the assembled address and byte toward the memory array. A wrong code, select or size sends the block back to idle without ever enabling its drivers. A frame strobe that falls in the middle of a transfer abandons that transfer.

The controller is one state machine with these states: IDLE, ADDR (seven clocks), SIZE, DATA (two clocks), HTAR (host drives 1111b), HFLT (bus floats, ownership moves to the target), SYNC (ready-sync driven, write request raised), TTAR (target drives 1111b) and TFLT (bus floats, ownership moves back to the host). Its transitions are: IDLE→ADDR when the select nibble matches after a valid opening; IDLE→IDLE otherwise; ADDR→ADDR until seven nibbles are in, then ADDR→SIZE; SIZE→DATA on 0000b, SIZE→IDLE on any other value; DATA→DATA, then DATA→HTAR; HTAR→HFLT→SYNC→TTAR→TFLT→IDLE. Any state other than IDLE goes to IDLE when the frame strobe is low.

Top module: `nib_fwwr_target`

## Requirements
- R1: The opening code is the `bus_in` value sampled at the last rising edge with `frame_n` low before it goes high. Only 1110b opens a write; any other last value leaves the block idle. An earlier low-strobe nibble does not count.
- R2: The nibble sampled at the first rising edge with `frame_n` high after the opening is the select. The block goes on only if it equals `id_strap`. On a mismatch `bus_oe` stays low and `wr_req` is never raised.
- R3: The next seven nibbles form `wr_addr`. The first one is bits 27:24 and the seventh is bits 3:0.
- R4: The nibble after the address is the size. Only 0000b continues the transfer. Any other value returns the block to idle with no drive and no write request.
- R5: The two nibbles after the size form `wr_data`. The first is bits 3:0 and the second is bits 7:4.
- R6: In the two clocks after the second data nibble (host turnaround, then float), `bus_oe` stays low.
- R7: In the 15th clock of a transfer, counting the opening clock as the 1st, `bus_oe` is 1 and `bus_out` is 0000b. `wr_req` is high for that single clock only, with `wr_addr` and `wr_data` holding the collected values.
- R8: In the 16th clock `bus_oe` is 1 and `bus_out` is 1111b. From the 17th clock on, `bus_oe` is 0.
- R9: If `frame_n` is low at any rising edge while a transfer is in progress, then from the next clock `bus_oe` is 0 and no write request is raised for that transfer.
- R10: The clock in which R9 aborts a transfer also counts as a frame-low clock under R1. A 1110b nibble there starts a new transfer.
- R11: While reset is held and right after it, `bus_oe` and `wr_req` are 0, and `wr_addr` and `wr_data` are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every field is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble seen on the shared bus lines |
| bus_out | output | 4 | Nibble the target drives when enabled |
| bus_oe | output | 1 | Target driver enable for the shared lines |
| id_strap | input | 4 | Device select strap compared with the select nibble |
| wr_req | output | 1 | One-clock write request toward the memory array |
| wr_addr | output | 28 | Collected write address |
| wr_data | output | 8 | Collected write byte |

## Verification
The hardest case to reach from the ports is a strobe that falls in the middle of a transfer and, in that same clock, carries the opening code for a new transfer. The abort and the restart then share one edge, and the select nibble of the new transfer arrives in the very next clock. The bench runs an address phase, stops the transfer at a chosen beat with the strobe low and 1110b on the bus, and then continues straight into the select, address and data of a second transfer. It expects a full ready-sync response from that second transfer alone. Separate runs stop transfers in the address phase and in the float clock just before ready-sync, and the bench checks that the drivers never turn on.

// File: rtl/nfw_pkg.sv
package nfw_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SIZE,
        ST_DATA,
        ST_HTAR,
        ST_HFLT,
        ST_SYNC,
        ST_TTAR,
        ST_TFLT
    } nfw_state_e;

endpackage

// File: rtl/nfw_start_detect.sv
module nfw_start_detect
    import nfw_pkg::*;
#(
    parameter logic [NIB_W-1:0] START_CODE = 4'hE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    output logic             start_hit
);

    logic armed_q;

    // Every frame-low clock overwrites the flag, so only the last one counts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!frame_n) begin
            armed_q <= (bus_in == START_CODE);
        end else begin
            armed_q <= 1'b0;
        end
    end

    // High in the first frame-high clock after a valid opening (the select clock).
    assign start_hit = armed_q & frame_n;

endmodule

// File: rtl/nfw_fsm.sv
module nfw_fsm
    import nfw_pkg::*;
#(
    parameter int               ADDR_BEATS = 7,
    parameter int               DATA_BEATS = 2,
    parameter logic [NIB_W-1:0] SIZE_CODE  = 4'h0,
    parameter logic [NIB_W-1:0] SYNC_CODE  = 4'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] id_strap,
    input  logic             start_hit,
    output logic             shift_addr,
    output logic             shift_data,
    output logic [NIB_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             wr_req
);

    localparam int MAX_BEATS = (ADDR_BEATS > DATA_BEATS) ? ADDR_BEATS : DATA_BEATS;
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam logic [BEAT_W-1:0] ADDR_LAST = BEAT_W'(ADDR_BEATS - 1);
    localparam logic [BEAT_W-1:0] DATA_LAST = BEAT_W'(DATA_BEATS - 1);

    nfw_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              abort;

    assign abort = !frame_n && (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        if (abort) begin
            state_d = ST_IDLE;
            beat_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    beat_d = '0;
                    if (start_hit && (bus_in == id_strap)) begin
                        state_d = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (beat_q == ADDR_LAST) begin
                        state_d = ST_SIZE;
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + BEAT_W'(1);
                    end
                end
                ST_SIZE: begin
                    state_d = (bus_in == SIZE_CODE) ? ST_DATA : ST_IDLE;
                    beat_d  = '0;
                end
                ST_DATA: begin
                    if (beat_q == DATA_LAST) begin
                        state_d = ST_HTAR;
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + BEAT_W'(1);
                    end
                end
                ST_HTAR: state_d = ST_HFLT;
                ST_HFLT: state_d = ST_SYNC;
                ST_SYNC: state_d = ST_TTAR;
                ST_TTAR: state_d = ST_TFLT;
                ST_TFLT: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        bus_oe     = 1'b0;
        bus_out    = '1;
        wr_req     = 1'b0;
        shift_addr = 1'b0;
        shift_data = 1'b0;
        unique case (state_q)
            ST_ADDR: shift_addr = frame_n;
            ST_DATA: shift_data = frame_n;
            ST_SYNC: begin
                bus_oe  = 1'b1;
                bus_out = SYNC_CODE;
                wr_req  = 1'b1;
            end
            ST_TTAR: begin
                bus_oe  = 1'b1;
                bus_out = '1;
            end
            default: begin
                bus_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nfw_payload.sv
module nfw_payload
    import nfw_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  bus_in,
    input  logic              shift_addr,
    input  logic              shift_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    // Address: high nibble first, so shift toward the top.
    generate
        if (ADDR_W == NIB_W) begin : g_addr_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          addr <= '0;
                else if (shift_addr) addr <= bus_in;
            end
        end else begin : g_addr_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          addr <= '0;
                else if (shift_addr) addr <= {addr[ADDR_W-NIB_W-1:0], bus_in};
            end
        end
    endgenerate

    // Data: low nibble first, so shift toward the bottom.
    generate
        if (DATA_W == NIB_W) begin : g_data_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          data <= '0;
                else if (shift_data) data <= bus_in;
            end
        end else begin : g_data_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          data <= '0;
                else if (shift_data) data <= {bus_in, data[DATA_W-1:NIB_W]};
            end
        end
    endgenerate

endmodule

// File: rtl/nib_fwwr_target.sv
module nib_fwwr_target
    import nfw_pkg::*;
#(
    parameter int               ADDR_W     = 28,
    parameter int               DATA_W     = 8,
    parameter logic [3:0]       START_CODE = 4'hE,
    parameter logic [3:0]       SIZE_CODE  = 4'h0,
    parameter logic [3:0]       SYNC_CODE  = 4'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [3:0]        id_strap,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int ADDR_BEATS = ADDR_W / NIB_W;
    localparam int DATA_BEATS = DATA_W / NIB_W;

    logic start_hit;
    logic shift_addr;
    logic shift_data;

    nfw_start_detect #(
        .START_CODE (START_CODE)
    ) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .bus_in    (bus_in),
        .start_hit (start_hit)
    );

    nfw_fsm #(
        .ADDR_BEATS (ADDR_BEATS),
        .DATA_BEATS (DATA_BEATS),
        .SIZE_CODE  (SIZE_CODE),
        .SYNC_CODE  (SYNC_CODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .bus_in     (bus_in),
        .id_strap   (id_strap),
        .start_hit  (start_hit),
        .shift_addr (shift_addr),
        .shift_data (shift_data),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .wr_req     (wr_req)
    );

    nfw_payload #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_payload (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .shift_addr (shift_addr),
        .shift_data (shift_data),
        .addr       (wr_addr),
        .data       (wr_data)
    );

endmodule

// File: rtl/nfw_checker.sv
module nfw_checker #(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic [3:0]        bus_out,
    input logic              bus_oe,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    a_r7_sync_value: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (bus_oe && bus_out == 4'h0));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    a_r7_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ($stable(wr_addr) && $stable(wr_data)));

    a_r8_tar_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && frame_n) |=> (bus_oe && bus_out == 4'hF));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !wr_req) |=> !bus_oe);

    a_r6_drive_starts_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> wr_req);

    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (!bus_oe && !wr_req));

endmodule

bind nib_fwwr_target nfw_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_nfw_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/test_nib_fwwr_target.sv
`timescale 1ns/1ps
module test_nib_fwwr_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  id_strap = 4'h0;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        wr_req;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;

    always #4 clk = ~clk;

    nib_fwwr_target i_nib_fwwr_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .id_strap (id_strap),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic       obs_oe  [1:18];
    logic [3:0] obs_out [1:18];
    logic       obs_wr  [1:18];
    int          wr_count;
    logic [27:0] got_addr;
    logic [7:0]  got_data;

    typedef struct packed {
        logic [3:0]  strap;
        logic [3:0]  start;
        logic [3:0]  idsel;
        logic [27:0] addr;
        logic [3:0]  size;
        logic [7:0]  data;
        logic        hit;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{4'h5, 4'hE, 4'h5, 28'hABCDEF1, 4'h0, 8'h3C, 1'b1},
        '{4'h5, 4'hE, 4'h6, 28'hABCDEF1, 4'h0, 8'h3C, 1'b0},
        '{4'h0, 4'hE, 4'h0, 28'h0000000, 4'h0, 8'hFF, 1'b1},
        '{4'hF, 4'hE, 4'hF, 28'hFFFFFFF, 4'h0, 8'h00, 1'b1},
        '{4'h5, 4'hD, 4'h5, 28'h1234567, 4'h0, 8'h11, 1'b0},
        '{4'h5, 4'hE, 4'h5, 28'h1234567, 4'h1, 8'hAA, 1'b0},
        '{4'hA, 4'hE, 4'hA, 28'h8000001, 4'h0, 8'hA5, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sample(input int k);
        obs_oe[k]  = bus_oe;
        obs_out[k] = bus_out;
        obs_wr[k]  = wr_req;
        if (wr_req) begin
            wr_count++;
            got_addr = wr_addr;
            got_data = wr_data;
        end
    endtask

    // Entered and left at a falling edge. Beat k is sampled by rising edge k.
    task automatic run_frame(input logic [3:0] strap, input logic [3:0] start,
                             input logic [3:0] idsel, input logic [27:0] addr,
                             input logic [3:0] size, input logic [7:0] data,
                             input bit use_pre, input logic [3:0] pre,
                             input int abort_at, input logic [3:0] abort_nib,
                             input bit no_start);
        logic [3:0] nib;
        logic       frm;
        id_strap = strap;
        wr_count = 0;
        for (int i = 1; i <= 18; i++) begin
            obs_oe[i] = 1'b0; obs_out[i] = 4'hF; obs_wr[i] = 1'b0;
        end
        if (use_pre) begin
            frame_n = 1'b0; bus_in = pre;
            @(posedge clk); @(negedge clk);
        end
        for (int k = 1; k <= 18; k++) begin
            if (k == 1 && no_start) continue;
            frm = 1'b1;
            nib = 4'hF;
            if (k == 1) begin frm = 1'b0; nib = start; end
            else if (k == 2) nib = idsel;
            else if (k <= 9) nib = addr[27 - 4*(k-3) -: 4];
            else if (k == 10) nib = size;
            else if (k == 11) nib = data[3:0];
            else if (k == 12) nib = data[7:4];
            if (k == abort_at) begin frm = 1'b0; nib = abort_nib; end
            frame_n = frm; bus_in = nib;
            @(posedge clk); @(negedge clk);
            sample(k);
            if (k == abort_at) return;
        end
        frame_n = 1'b1; bus_in = 4'hF;
    endtask

    task automatic idle_cycles(input int n);
        frame_n = 1'b1; bus_in = 4'hF;
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic expect_hit(input string tag, input logic [27:0] addr,
                              input logic [7:0] data);
        bit early;
        chk(obs_oe[14] && obs_out[14] == 4'h0, "R7", {tag, " sync drive"},
            {27'd0, obs_oe[14], obs_out[14]}, 32'h10);
        chk(obs_wr[14] && wr_count == 1, "R7", {tag, " single write request"},
            wr_count, 1);
        chk(got_addr == addr, "R3", {tag, " address"}, got_addr, addr);
        chk(got_data == data, "R5", {tag, " data"}, got_data, data);
        chk(obs_oe[15] && obs_out[15] == 4'hF, "R8", {tag, " target turnaround"},
            {27'd0, obs_oe[15], obs_out[15]}, 32'h1F);
        chk(!obs_oe[16] && !obs_oe[17], "R8", {tag, " release"},
            {obs_oe[16], obs_oe[17]}, 0);
        early = 1'b0;
        for (int i = 2; i <= 13; i++) if (obs_oe[i]) early = 1'b1;
        chk(!early, "R6", {tag, " no drive before sync"}, early, 0);
    endtask

    task automatic expect_quiet(input string req, input string tag);
        bit any;
        any = 1'b0;
        for (int i = 1; i <= 18; i++) if (obs_oe[i]) any = 1'b1;
        chk(!any, req, {tag, " drivers stay off"}, any, 0);
        chk(wr_count == 0, req, {tag, " no write request"}, wr_count, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        // R11: reset state
        @(negedge clk);
        chk(!bus_oe && !wr_req, "R11", "outputs during reset", {bus_oe, wr_req}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_oe && !wr_req, "R11", "outputs after reset", {bus_oe, wr_req}, 0);
        chk(wr_addr == 28'd0 && wr_data == 8'd0, "R11", "payload after reset",
            {wr_addr[23:0], wr_data}, 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VECS[v].strap, VECS[v].start, VECS[v].idsel, VECS[v].addr,
                      VECS[v].size, VECS[v].data, 1'b0, 4'h0, 0, 4'h0, 1'b0);
            if (VECS[v].hit) expect_hit($sformatf("vec%0d", v), VECS[v].addr, VECS[v].data);
            else expect_quiet(VECS[v].start != 4'hE ? "R1" :
                              VECS[v].idsel != VECS[v].strap ? "R2" : "R4",
                              $sformatf("vec%0d", v));
            idle_cycles(1);
        end

        // R1: earlier frame-low nibble is overridden by the last one
        run_frame(4'h3, 4'h7, 4'h3, 28'h5A5A5A5, 4'h0, 8'h69, 1'b1, 4'hE, 0, 4'h0, 1'b0);
        expect_quiet("R1", "last-low not start");
        idle_cycles(1);
        run_frame(4'h3, 4'hE, 4'h3, 28'h5A5A5A5, 4'h0, 8'h69, 1'b1, 4'h7, 0, 4'h0, 1'b0);
        expect_hit("R1 last-low start", 28'h5A5A5A5, 8'h69);
        idle_cycles(1);

        // R9: abort in address phase and in the float clock before sync
        run_frame(4'h2, 4'hE, 4'h2, 28'h0F0F0F0, 4'h0, 8'h81, 1'b0, 4'h0, 5, 4'hF, 1'b0);
        idle_cycles(20);
        chk(!bus_oe && !wr_req, "R9", "abort in address phase quiet",
            {bus_oe, wr_req}, 0);
        expect_quiet("R9", "abort addr");
        run_frame(4'h2, 4'hE, 4'h2, 28'h0F0F0F0, 4'h0, 8'h81, 1'b0, 4'h0, 14, 4'hF, 1'b0);
        expect_quiet("R9", "abort before sync");
        idle_cycles(20);
        chk(!bus_oe && !wr_req, "R9", "abort before sync stays idle",
            {bus_oe, wr_req}, 0);

        // R10: aborting clock carries a new opening code
        run_frame(4'h9, 4'hE, 4'h9, 28'h1111111, 4'h0, 8'h22, 1'b0, 4'h0, 6, 4'hE, 1'b0);
        chk(wr_count == 0, "R10", "aborted transfer writes nothing", wr_count, 0);
        run_frame(4'h9, 4'hE, 4'h9, 28'hC0FFEE7, 4'h0, 8'h5B, 1'b0, 4'h0, 0, 4'h0, 1'b1);
        expect_hit("R10 restart", 28'hC0FFEE7, 8'h5B);
        idle_cycles(2);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule